// File: doc/BRIEF.md
# Prioritized Command-Queue Trigger Controller

This block decides when each of several command queues may hand a conversion command to one shared converter command port. Every queue has a trigger mode, a trigger input and a two-bit status. The block watches the trigger inputs and moves each queue between idle, waiting and triggered. It grants the port to the triggered queue with the lowest index. It then follows the handshake of each command through to completion.

Edge-scan queues are started by a selected edge on their trigger input. They drop back to waiting when a completed command carries an end-of-queue or pause marker. Level-scan queues run while their gate input is at its active level and take no notice of those markers. A gate that closes while a command from that queue is on the serial link takes effect only when that command finishes. The block keeps a command pointer for each queue and records, for each destination, which queue last sent a command there.

The command store, the serial shifter and the converter sit outside the block. The environment sees `req_o` together with the queue index and pointer. It answers with a one-cycle `done_i` that carries the command's markers and destination.

Top module: `qtrig_ctrl`

## Requirements
- R1: While reset is active, and on the first cycle after it, every queue status is 00, `req_o` is 0 and every last-queue record is 0.
- R2: Mode codes are 00 off, 01 edge scan, 10 level scan and 11 off. A queue in either off code reads status 00 (idle) one clock later. An idle queue in an active mode moves to 01 (waiting) on the next clock.
- R3: In edge mode a waiting queue becomes 10 (triggered) when its registered trigger shows the selected edge: rising when its edge-select bit is 1, falling when it is 0. The status changes two clocks after the input changes. The opposite edge leaves the queue waiting.
- R4: In edge mode a completed command that carries the end-of-queue or pause marker returns the queue to waiting, and no new request follows. The end-of-queue marker also resets that queue's pointer to 0 in every mode.
- R5: In level mode a waiting queue becomes triggered while its registered trigger equals its gate-level bit. Completed commands that carry either marker leave it triggered.
- R6: In level mode, when the gate closes and no command from that queue is in flight, the queue returns to waiting two clocks after the input changes.
- R7: In level mode, when the gate closes while a command from that queue is in flight, the queue stays triggered until that command's `done_i`, and returns to waiting on that clock.
- R8: When no command is in flight, the port is granted on the next clock to the triggered queue with the lowest index. While a command is in flight, `req_o` stays high and `qsel_o` does not change until `done_i`.
- R9: A triggered queue held back by a higher-priority transfer keeps status 10. It is granted once the higher-priority queue is no longer triggered.
- R10: On `done_i`, the record for the destination given by `dest_i` takes the index of the queue whose command completed.
- R11: Each queue has its own pointer. It starts at 0, steps by one on every completed command without end-of-queue, and appears on `ptr_o` while that queue's request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2*NQ | Mode for each queue, 2 bits per queue (queue i at bits 2i+1:2i) |
| edge_sel_i | input | NQ | Edge select per queue, 1 = rising, 0 = falling |
| gate_lvl_i | input | NQ | Active gate level per queue for level mode |
| trig_i | input | NQ | Trigger or gate input per queue |
| done_i | input | 1 | One-cycle completion of the command in flight |
| eoq_i | input | 1 | Completed command carries the end-of-queue marker |
| pause_i | input | 1 | Completed command carries the pause marker |
| dest_i | input | DW | Destination of the completed command |
| req_o | output | 1 | A command transfer is requested or in flight |
| qsel_o | output | QW | Index of the granted queue |
| ptr_o | output | PTR_W | Command pointer of the granted queue |
| status_o | output | 2*NQ | Status per queue: 00 idle, 01 waiting, 10 triggered |
| last_q_o | output | ND*QW | Last queue recorded per destination (destination d at bits d*QW +: QW) |

## Verification
The embedded properties check several rules on every clock. A grant only goes to a queue that was triggered, and no lower-index queue was triggered at the time. The selection holds while a command is in flight. Off modes force idle. Each status step follows its mode's rule, including the deferred and immediate effects of a gate close. Pointer reset and pointer stepping, and the per-destination record, are checked on each completion. Only the bench scenarios can show the sequences that span several queues: a lower-priority queue waiting through a higher one's transfer and then being served, a gate that closes mid-transfer on one queue while a second queue stays busy, and how the pointers progress over a mixed run of edge and level commands.

// File: rtl/qtc_pkg.sv
// Shared encodings for the queue trigger controller.
package qtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_TRIG = 2'b10
    } qstat_e;

    localparam logic [1:0] MD_OFF   = 2'b00;
    localparam logic [1:0] MD_EDGE  = 2'b01;
    localparam logic [1:0] MD_LEVEL = 2'b10;
    localparam logic [1:0] MD_OFF2  = 2'b11;
endpackage

// File: rtl/qtc_trig_cond.sv
// Registers each trigger input and derives the edge hit and gate-open
// conditions from the registered copy. Assumes trig_i is synchronous to clk.
module qtc_trig_cond #(
    parameter int NQ = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] trig_i,
    input  logic [NQ-1:0] edge_sel_i,
    input  logic [NQ-1:0] gate_lvl_i,
    output logic [NQ-1:0] edge_hit_o,
    output logic [NQ-1:0] gate_open_o
);
    logic [NQ-1:0] trig_q;
    logic [NQ-1:0] trig_qq;

    // Two-stage history of the trigger inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q  <= '0;
            trig_qq <= '0;
        end else begin
            trig_q  <= trig_i;
            trig_qq <= trig_q;
        end
    end

    // Edge of the selected polarity and gate level match per queue.
    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            edge_hit_o[i]  = edge_sel_i[i] ? (trig_q[i] & ~trig_qq[i])
                                           : (~trig_q[i] & trig_qq[i]);
            gate_open_o[i] = (trig_q[i] == gate_lvl_i[i]);
        end
    end
endmodule

// File: rtl/qtc_queue_fsm.sv
// Status machine of one queue: idle, waiting for trigger, triggered.
// Assumes done_i is only high when this queue's command completes and
// in_flight_i marks a command of this queue being granted or transferred.
module qtc_queue_fsm
    import qtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       edge_hit_i,
    input  logic       gate_open_i,
    input  logic       in_flight_i,
    input  logic       done_i,
    input  logic       eoq_i,
    input  logic       pause_i,
    output logic [1:0] status_o
);
    qstat_e st_q;
    qstat_e st_d;
    logic   off;

    assign off      = (mode_i == MD_OFF) || (mode_i == MD_OFF2);
    assign status_o = st_q;

    // Next-status rules per mode.
    always_comb begin
        st_d = st_q;
        if (off) begin
            st_d = ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: st_d = ST_WAIT;
                ST_WAIT: begin
                    if (mode_i == MD_EDGE ? edge_hit_i : gate_open_i)
                        st_d = ST_TRIG;
                end
                ST_TRIG: begin
                    if (mode_i == MD_EDGE) begin
                        if (done_i && (eoq_i || pause_i)) st_d = ST_WAIT;
                    end else if (!gate_open_i && (!in_flight_i || done_i)) begin
                        st_d = ST_WAIT;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    p_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != 2'b11);
    p_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> st_q == ST_IDLE);
    p_edge_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_EDGE && st_q == ST_WAIT && edge_hit_i) |=> st_q == ST_TRIG);
    p_edge_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_EDGE && st_q == ST_TRIG && done_i && (eoq_i || pause_i))
        |=> st_q == ST_WAIT);
    p_level_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_LEVEL && st_q == ST_TRIG && gate_open_i && done_i)
        |=> st_q == ST_TRIG);
    p_close_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_LEVEL && st_q == ST_TRIG && !in_flight_i && !gate_open_i)
        |=> st_q == ST_WAIT);
    p_close_defer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_LEVEL && st_q == ST_TRIG && in_flight_i && !done_i)
        |=> st_q == ST_TRIG);
endmodule

// File: rtl/qtc_arbiter.sv
// Fixed-priority pick among triggered queues; the lowest index wins.
// Purely combinational; the caller decides when a pick is taken.
module qtc_arbiter #(
    parameter int NQ = 4,
    parameter int QW = 2
) (
    input  logic [NQ-1:0] cand_i,
    output logic          gnt_valid_o,
    output logic [QW-1:0] gnt_idx_o
);
    // Scan from the highest index down so the lowest index is kept last.
    always_comb begin
        gnt_valid_o = 1'b0;
        gnt_idx_o   = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                gnt_valid_o = 1'b1;
                gnt_idx_o   = QW'(i);
            end
        end
    end
endmodule

// File: rtl/qtc_xfer_track.sv
// Tracks the command in flight: takes a grant only at a command boundary,
// keeps the per-queue pointers and the last-queue record per destination.
// Assumes done_i is a one-cycle pulse; it is ignored while nothing is in flight.
module qtc_xfer_track #(
    parameter int NQ    = 4,
    parameter int QW    = 2,
    parameter int PTR_W = 4,
    parameter int ND    = 2,
    parameter int DW    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gnt_valid_i,
    input  logic [QW-1:0]    gnt_idx_i,
    input  logic             done_i,
    input  logic             eoq_i,
    input  logic [DW-1:0]    dest_i,
    output logic             busy_o,
    output logic [QW-1:0]    act_o,
    output logic             done_eff_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic [ND*QW-1:0] last_q_o
);
    logic             busy_q;
    logic [QW-1:0]    act_q;
    logic [PTR_W-1:0] ptr_q  [NQ];
    logic [QW-1:0]    last_q [ND];

    assign busy_o     = busy_q;
    assign act_o      = act_q;
    assign done_eff_o = busy_q && done_i;
    assign ptr_o      = ptr_q[act_q];

    // Grant at a boundary, release on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            act_q  <= '0;
        end else if (!busy_q && gnt_valid_i) begin
            busy_q <= 1'b1;
            act_q  <= gnt_idx_i;
        end else if (busy_q && done_i) begin
            busy_q <= 1'b0;
        end
    end

    // Per-queue command pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NQ; i++) ptr_q[i] <= '0;
        end else if (busy_q && done_i) begin
            ptr_q[act_q] <= eoq_i ? '0 : ptr_q[act_q] + PTR_W'(1);
        end
    end

    // Last queue that completed a command toward each destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < ND; d++) last_q[d] <= '0;
        end else if (busy_q && done_i && (int'(dest_i) < ND)) begin
            last_q[dest_i] <= act_q;
        end
    end

    for (genvar d = 0; d < ND; d++) begin : g_last
        assign last_q_o[d*QW +: QW] = last_q[d];
    end

    p_hold_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !done_i) |=> (busy_q && act_q == $past(act_q)));
    p_eoq_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && done_i && eoq_i) |=> ptr_o == '0);
    p_ptr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && done_i && !eoq_i) |=> ptr_o == $past(ptr_o) + PTR_W'(1));
    p_last_rec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && done_i && (int'(dest_i) < ND))
        |=> last_q[$past(dest_i)] == $past(act_q));
endmodule

// File: rtl/qtrig_ctrl.sv
// Top of the queue trigger controller: trigger conditioning, one status
// machine per queue, fixed-priority arbitration and transfer tracking.
// Assumes the environment answers each request with exactly one done_i.
module qtrig_ctrl
    import qtc_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int PTR_W = 4,
    parameter int ND    = 2,
    localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int DW   = (ND > 1) ? $clog2(ND) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2*NQ-1:0]  mode_i,
    input  logic [NQ-1:0]    edge_sel_i,
    input  logic [NQ-1:0]    gate_lvl_i,
    input  logic [NQ-1:0]    trig_i,
    input  logic             done_i,
    input  logic             eoq_i,
    input  logic             pause_i,
    input  logic [DW-1:0]    dest_i,
    output logic             req_o,
    output logic [QW-1:0]    qsel_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic [2*NQ-1:0]  status_o,
    output logic [ND*QW-1:0] last_q_o
);
    logic [NQ-1:0] edge_hit;
    logic [NQ-1:0] gate_open;
    logic [NQ-1:0] trig_vec;
    logic          gnt_valid;
    logic [QW-1:0] gnt_idx;
    logic          busy;
    logic [QW-1:0] act;
    logic          done_eff;
    logic [NQ-1:0] sel_onehot;

    qtc_trig_cond #(.NQ(NQ)) u_cond (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .edge_sel_i(edge_sel_i),
        .gate_lvl_i(gate_lvl_i), .edge_hit_o(edge_hit), .gate_open_o(gate_open)
    );

    for (genvar i = 0; i < NQ; i++) begin : g_q
        logic in_flight;
        logic done_me;
        assign in_flight = (busy && act == QW'(i)) ||
                           (!busy && gnt_valid && gnt_idx == QW'(i));
        assign done_me   = done_eff && act == QW'(i);
        assign trig_vec[i] = (status_o[2*i +: 2] == ST_TRIG);

        qtc_queue_fsm u_fsm (
            .clk(clk), .rst_n(rst_n), .mode_i(mode_i[2*i +: 2]),
            .edge_hit_i(edge_hit[i]), .gate_open_i(gate_open[i]),
            .in_flight_i(in_flight), .done_i(done_me), .eoq_i(eoq_i),
            .pause_i(pause_i), .status_o(status_o[2*i +: 2])
        );
    end

    qtc_arbiter #(.NQ(NQ), .QW(QW)) u_arb (
        .cand_i(trig_vec), .gnt_valid_o(gnt_valid), .gnt_idx_o(gnt_idx)
    );

    qtc_xfer_track #(.NQ(NQ), .QW(QW), .PTR_W(PTR_W), .ND(ND), .DW(DW)) u_trk (
        .clk(clk), .rst_n(rst_n), .gnt_valid_i(gnt_valid), .gnt_idx_i(gnt_idx),
        .done_i(done_i), .eoq_i(eoq_i), .dest_i(dest_i), .busy_o(busy),
        .act_o(act), .done_eff_o(done_eff), .ptr_o(ptr_o), .last_q_o(last_q_o)
    );

    assign req_o      = busy;
    assign qsel_o     = act;
    assign sel_onehot = {{(NQ-1){1'b0}}, 1'b1} << act;

    p_grant_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> |($past(trig_vec) & sel_onehot));
    p_grant_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> (($past(trig_vec) & (sel_onehot - NQ'(1))) == '0));
endmodule

// File: tb/qtrig_ctrl_bench.sv
module qtrig_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NQ = 4;
    localparam int QW = 2;
    localparam int PW = 4;
    localparam logic [1:0] WAITS = 2'b01;
    localparam logic [1:0] TRIGD = 2'b10;

    // {mode[1:0], eoq, pause, expected status[1:0], dest}, run on queue 2
    localparam logic [6:0] VECS [0:8] = '{
        7'b01_0_0_10_0, 7'b01_0_0_10_1, 7'b01_0_1_01_0,
        7'b01_1_0_01_1, 7'b10_0_0_10_0, 7'b10_0_1_10_1,
        7'b10_1_0_10_0, 7'b01_0_0_10_1, 7'b01_1_0_01_0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2*NQ-1:0] mode = '0;
    logic [NQ-1:0] edge_sel = 4'b1101;
    logic [NQ-1:0] gate_lvl = 4'b0111;
    logic [NQ-1:0] trig = '0;
    logic done = 1'b0, eoq = 1'b0, pause = 1'b0;
    logic [0:0] dest = '0;
    logic req;
    logic [QW-1:0] qsel;
    logic [PW-1:0] ptr;
    logic [2*NQ-1:0] status;
    logic [2*QW-1:0] lastq;

    int checks = 0, fails = 0, cyc = 0;
    bit ended = 1'b0;
    int exp_ptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qtrig_ctrl u_qtrig_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .edge_sel_i(edge_sel),
        .gate_lvl_i(gate_lvl), .trig_i(trig), .done_i(done), .eoq_i(eoq),
        .pause_i(pause), .dest_i(dest), .req_o(req), .qsel_o(qsel),
        .ptr_o(ptr), .status_o(status), .last_q_o(lastq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic wait_req();
        for (int k = 0; k < 12 && !req; k++) @(negedge clk);
        chk("R8 request raised", int'(req), 1);
    endtask

    task automatic complete(input logic e, input logic p, input logic d);
        done = 1'b1; eoq = e; pause = p; dest = d;
        @(negedge clk);
        done = 1'b0; eoq = 1'b0; pause = 1'b0;
    endtask

    function automatic int st(input int q);
        return int'(status[2*q +: 2]);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !ended) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            report();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 status in reset", int'(status), 0);
        chk("R1 req in reset", int'(req), 0);
        chk("R1 last record in reset", int'(lastq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after reset", int'(status), 0);

        // Table: queue 2 through edge and level commands (R4 R5 R10 R11)
        for (int v = 0; v < 9; v++) begin
            logic [6:0] t;
            t = VECS[v];
            mode[5:4] = t[6:5];
            @(negedge clk);
            if (t[6:5] == 2'b01 && status[5:4] == WAITS) begin
                trig[2] = 1'b0;
                repeat (2) @(negedge clk);
                trig[2] = 1'b1;
            end else if (t[6:5] == 2'b10) begin
                trig[2] = 1'b1;
            end
            wait_req();
            chk("R8 table qsel", int'(qsel), 2);
            chk("R11 table pointer", int'(ptr), exp_ptr);
            complete(t[4], t[3], t[0]);
            chk("R4/R5 table status after done", st(2), int'(t[2:1]));
            chk("R10 table last record", int'(lastq[t[0]*QW +: QW]), 2);
            exp_ptr = t[4] ? 0 : exp_ptr + 1;
        end
        mode[5:4] = 2'b00;
        @(negedge clk);
        chk("R4 no request after end-of-queue", int'(req), 0);
        chk("R2 off mode idles queue 2", st(2), 0);

        // R3: queue 1 edge mode with falling select; rising is ignored
        mode[3:2] = 2'b01;
        repeat (2) @(negedge clk);
        chk("R2 idle to waiting", st(1), int'(WAITS));
        trig[1] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 opposite edge ignored", st(1), int'(WAITS));
        chk("R3 no request on opposite edge", int'(req), 0);
        trig[1] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3 selected edge triggers", st(1), int'(TRIGD));
        @(negedge clk);
        chk("R8 grant queue 1", int'(req && qsel == 1), 1);
        chk("R11 queue 1 first pointer", int'(ptr), 0);

        // R9: queue 3 level (active low) waits behind queue 1
        mode[7:6] = 2'b10;
        repeat (3) @(negedge clk);
        chk("R9 held queue stays triggered", st(3), int'(TRIGD));
        chk("R8 selection held during flight", int'(qsel), 1);
        complete(1'b0, 1'b1, 1'b1);
        chk("R4 pause returns queue 1 to waiting", st(1), int'(WAITS));
        @(negedge clk);
        chk("R9 queue 3 granted after queue 1", int'(req && qsel == 3), 1);
        chk("R11 queue 3 own pointer", int'(ptr), 0);
        chk("R10 record dest 1 = queue 1", int'(lastq[QW +: QW]), 1);

        // R7: gate closes while queue 3 is in flight; queue 1 triggers meanwhile
        trig[3] = 1'b1;
        trig[1] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 close deferred during flight", st(3), int'(TRIGD));
        chk("R8 no switch while in flight", int'(qsel), 3);
        trig[1] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3 queue 1 retriggered", st(1), int'(TRIGD));
        chk("R8 still queue 3", int'(req && qsel == 3), 1);
        complete(1'b0, 1'b0, 1'b0);
        chk("R7 close applied at done", st(3), int'(WAITS));
        @(negedge clk);
        chk("R8 queue 1 granted next", int'(req && qsel == 1), 1);
        chk("R11 queue 1 pointer stepped", int'(ptr), 1);
        chk("R10 record dest 0 = queue 3", int'(lastq[0 +: QW]), 3);

        // R6: queue 3 gate opens then closes while not in flight
        trig[3] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 gate open triggers queue 3", st(3), int'(TRIGD));
        trig[3] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 immediate close", st(3), int'(WAITS));
        complete(1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk("R4 no request after queue 1 end-of-queue", int'(req), 0);
        chk("R10 record dest 1 = queue 1", int'(lastq[QW +: QW]), 1);

        // R2: code 11 is off
        mode[3:2] = 2'b11;
        @(negedge clk);
        chk("R2 code 11 idles queue 1", st(1), 0);

        report();
    end
endmodule